// File: doc/BRIEF.md
# Jabber, Collision and Heartbeat Indicator

This block sits between the station-side attachment interface and a twisted-pair transmitter. It drives the control-in line toward the station. Three conditions can put a 10 MHz square wave on that line: a collision, a jabber lockout, or a short heartbeat burst after each transmission. The block also gates the transmit path off while jabber holds. It takes two carrier indications, one for data arriving from the station and one for data arriving from the cable. It also takes a link-good flag, a heartbeat enable strap and a loopback test strap. Carrier detection and the analog line drivers live outside this block.

The block runs from a 100 MHz clock, so one bit time is 10 cycles. The jabber limit, the unjab hold, the restart gap, the heartbeat delay and the heartbeat length are all counted in clock cycles and set by parameters. The defaults are 50 ms, 500 ms, 1 µs, 800 ns and 800 ns. While the loopback strap is set, the collision, jabber and heartbeat sources are all held off. Jabber, collision and heartbeat all drive the same waveform, so control-in is active whenever any of the three is active. A heartbeat that has not yet started is dropped when a new transmission begins.

Top module: `jab_col_sqe`

## Requirements
- R1: Whenever any source is active, `ci_out` toggles with a period of 2*HALF_CYC cycles. It is high for HALF_CYC of those cycles, starting high one cycle after the source appears.
- R2: A collision is `tx_crs` and `rx_crs` both high while `link_ok` is high and `loop_test` is low. Control-in goes quiet one cycle after either carrier drops.
- R3: After JAB_CYC consecutive sampled cycles of `tx_crs` high, `tx_en` goes low and control-in toggles. This holds even after `rx_crs` is gone.
- R4: Jabber clears after UNJAB_CYC consecutive cycles of `tx_crs` low. At that point `tx_en` returns high and control-in goes quiet. Any `tx_crs` high during the hold restarts the count.
- R5: `xmt_stat` equals `tx_crs` gated by `tx_en`. It is therefore low during jabber and during link failure. `rcv_stat` equals `rx_crs` gated by `link_ok`.
- R6: A low gap on `tx_crs` of at least GAP_CYC cycles restarts the jabber count. A shorter gap keeps the count, so the active time on both sides of the gap adds up.
- R7: With `sqe_en` high, a falling edge of `tx_crs` outside jabber is followed by a burst. The burst starts SQE_DLY+1 cycles after the edge and lasts SQE_LEN cycles, which gives SQE_LEN/(2*HALF_CYC) pulses. With `sqe_en` low there is no burst.
- R8: With `loop_test` high, `ci_out` stays low and `tx_en` is never removed by jabber. This holds for every carrier pattern.
- R9: If `tx_crs` rises before a pending heartbeat burst starts, the burst is dropped.
- R10: Reset clears every counter and the jabber state. After reset `ci_out` is low and `tx_en` equals `link_ok`. With `link_ok` low, `tx_en` is low and no collision is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz clock |
| rst_n | input | 1 | Active-low reset |
| tx_crs | input | 1 | Carrier from the station's transmit data |
| rx_crs | input | 1 | Carrier from the cable receiver |
| link_ok | input | 1 | Link integrity good |
| sqe_en | input | 1 | Heartbeat enable strap |
| loop_test | input | 1 | Loopback test strap |
| ci_out | output | 1 | Control-in square wave |
| tx_en | output | 1 | Transmit path enable |
| xmt_stat | output | 1 | Transmit status flag |
| rcv_stat | output | 1 | Receive status flag |

## Verification
The status flags and `tx_en` are combinational from the inputs and the jabber register. The bench therefore samples them within a few cycles of a change, or at fixed offsets around JAB_CYC and UNJAB_CYC so that both sides of each threshold are seen. `ci_out` is one register behind its source. Every control-in check counts rising edges and high samples over a window that opens at least two cycles after the stimulus. This makes the result independent of the wave's phase. For the heartbeat, the bench checks a quiet stretch shorter than SQE_DLY, then counts pulses in the following window.

// File: rtl/jab_col_sqe.sv
module jab_col_sqe #(
  parameter int HALF_CYC  = 5,
  parameter int JAB_CYC   = 5_000_000,
  parameter int UNJAB_CYC = 50_000_000,
  parameter int GAP_CYC   = 100,
  parameter int SQE_DLY   = 80,
  parameter int SQE_LEN   = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_crs,
  input  logic rx_crs,
  input  logic link_ok,
  input  logic sqe_en,
  input  logic loop_test,
  output logic ci_out,
  output logic tx_en,
  output logic xmt_stat,
  output logic rcv_stat
);
  localparam int JW = $clog2(JAB_CYC + 1);
  localparam int UW = $clog2(UNJAB_CYC + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam int HW = $clog2(SQE_DLY + SQE_LEN + 1);
  localparam int PW = $clog2(2 * HALF_CYC + 1);
  localparam logic [JW-1:0] JLAST = JW'(JAB_CYC - 1);
  localparam logic [UW-1:0] ULAST = UW'(UNJAB_CYC - 1);
  localparam logic [GW-1:0] GLAST = GW'(GAP_CYC - 1);
  localparam logic [HW-1:0] HLAST = HW'(SQE_DLY + SQE_LEN);
  localparam logic [HW-1:0] HDLY  = HW'(SQE_DLY);
  localparam logic [PW-1:0] PLAST = PW'(2 * HALF_CYC - 1);
  localparam logic [PW-1:0] PHALF = PW'(HALF_CYC);

  logic          jab, tx_q;
  logic [JW-1:0] jcnt;
  logic [UW-1:0] ucnt;
  logic [GW-1:0] gcnt;
  logic [HW-1:0] hcnt;
  logic [PW-1:0] phase;

  wire run    = !loop_test;
  wire col    = run & link_ok & tx_crs & rx_crs;
  wire hb_on  = hcnt > HDLY;
  wire ci_req = jab | col | hb_on;

  assign tx_en    = link_ok & ~jab;
  assign xmt_stat = tx_crs & tx_en;
  assign rcv_stat = rx_crs & link_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      jab <= 1'b0; jcnt <= '0; ucnt <= '0; gcnt <= '0;
    end else if (!run) begin
      jab <= 1'b0; jcnt <= '0; ucnt <= '0; gcnt <= '0;
    end else if (jab) begin
      if (tx_crs) ucnt <= '0;
      else if (ucnt == ULAST) begin
        jab <= 1'b0; ucnt <= '0; jcnt <= '0; gcnt <= '0;
      end else ucnt <= ucnt + 1'b1;
    end else if (tx_crs) begin
      gcnt <= '0;
      if (jcnt == JLAST) begin
        jab  <= 1'b1;
        jcnt <= '0;
      end else jcnt <= jcnt + 1'b1;
    end else if (gcnt == GLAST) jcnt <= '0;
    else gcnt <= gcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0; hcnt <= '0;
    end else begin
      tx_q <= tx_crs;
      if (!run || tx_crs) hcnt <= '0;
      else if (tx_q && !jab && sqe_en && link_ok) hcnt <= HW'(1);
      else if (hcnt == HLAST) hcnt <= '0;
      else if (hcnt != '0) hcnt <= hcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0; ci_out <= 1'b0;
    end else begin
      ci_out <= ci_req && (phase < PHALF);
      if (!ci_req || phase == PLAST) phase <= '0;
      else phase <= phase + 1'b1;
    end
  end
endmodule

module jcs_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_crs,
  input logic link_ok,
  input logic loop_test,
  input logic ci_out,
  input logic tx_en,
  input logic xmt_stat
);
  assert_ci_min_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ci_out) |=> ci_out);
  assert_jab_needs_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_en) && link_ok && $past(link_ok)) |-> $past(tx_crs));
  assert_unjab_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(tx_en) && link_ok && $past(link_ok) && !$past(loop_test)) |-> !$past(tx_crs));
  assert_xmt_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    xmt_stat |-> tx_en);
  assert_loop_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_test && $past(loop_test) && $past(loop_test, 2)) |-> !ci_out);
endmodule

bind jab_col_sqe jcs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_crs(tx_crs), .link_ok(link_ok),
  .loop_test(loop_test), .ci_out(ci_out), .tx_en(tx_en), .xmt_stat(xmt_stat)
);

// File: tb/sim_jab_col_sqe.sv
module sim_jab_col_sqe;
  localparam int HALF = 5, JAB = 400, UNJ = 600, GAP = 100, DLY = 80, LEN = 80;
  localparam int NV = 8;
  // {loop, link, tx, rx, exp_xmt, exp_rcv, exp_txen, exp_col}
  localparam logic [7:0] VEC [NV] = '{
    8'b0100_0010, 8'b0110_1010, 8'b0111_1111, 8'b0101_0110,
    8'b0111_1111, 8'b0110_1010, 8'b1111_1110, 8'b0011_0000
  };

  logic clk = 0, rst_n = 0;
  logic tx_crs = 0, rx_crs = 0, link_ok = 1, sqe_en = 0, loop_test = 0;
  logic ci_out, tx_en, xmt_stat, rcv_stat;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  jab_col_sqe #(.HALF_CYC(HALF), .JAB_CYC(JAB), .UNJAB_CYC(UNJ), .GAP_CYC(GAP),
                .SQE_DLY(DLY), .SQE_LEN(LEN)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_crs(tx_crs), .rx_crs(rx_crs), .link_ok(link_ok),
    .sqe_en(sqe_en), .loop_test(loop_test), .ci_out(ci_out), .tx_en(tx_en),
    .xmt_stat(xmt_stat), .rcv_stat(rcv_stat));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic watch(input int n, output int rises, output int highs);
    logic prev;
    prev = ci_out; rises = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      tick(1);
      if (ci_out && !prev) rises++;
      if (ci_out) highs++;
      prev = ci_out;
    end
  endtask

  initial begin
    int r, h;
    tick(3);
    rst_n = 1;
    tick(2);
    check("R10 reset ci_out", ci_out, 0);
    check("R10 reset tx_en", tx_en, 1);

    for (int v = 0; v < NV; v++) begin
      {loop_test, link_ok, tx_crs, rx_crs} = VEC[v][7:4];
      tick(3);
      check($sformatf("R5 xmt vec%0d", v), xmt_stat, VEC[v][3]);
      check($sformatf("R5 rcv vec%0d", v), rcv_stat, VEC[v][2]);
      check($sformatf("R10 tx_en vec%0d", v), tx_en, VEC[v][1]);
      watch(20, r, h);
      check($sformatf("R2 pulses vec%0d", v), r, VEC[v][0] ? 2 : 0);
      if (VEC[v][0]) check($sformatf("R1 high time vec%0d", v), h, 2 * HALF);
    end
    {loop_test, link_ok, tx_crs, rx_crs} = 4'b0100;
    tick(GAP + 10);

    // jabber entry, r3_
    tx_crs = 1; rx_crs = 1;
    tick(JAB - 2);
    check("R3 tx_en before limit", tx_en, 1);
    tick(4);
    rx_crs = 0;
    check("R3 tx_en after limit", tx_en, 0);
    check("R5 xmt in jabber", xmt_stat, 0);
    tick(2);
    watch(20, r, h);
    check("R3 jabber pulses", r, 2);
    // unjab hold
    tx_crs = 0;
    tick(UNJ - 10);
    check("R4 still jabbed", tx_en, 0);
    tick(20);
    check("R4 released", tx_en, 1);
    watch(20, r, h);
    check("R4 ci quiet", r, 0);

    // short gap accumulates
    tick(GAP);
    tx_crs = 1; tick(300); tx_crs = 0; tick(50); tx_crs = 1; tick(110);
    check("R6 short gap jabs", tx_en, 0);
    tx_crs = 0; tick(UNJ + 10);
    check("R6 recovered", tx_en, 1);
    tx_crs = 1; tick(300); tx_crs = 0; tick(GAP + 50); tx_crs = 1; tick(300);
    check("R6 long gap restarts", tx_en, 1);
    tx_crs = 0; tick(GAP + 10);

    // heartbeat
    sqe_en = 1;
    tx_crs = 1; tick(50); tx_crs = 0;
    watch(DLY - 10, r, h);
    check("R7 quiet before burst", h, 0);
    watch(150, r, h);
    check("R7 burst pulses", r, LEN / (2 * HALF));
    // cancellation, r9_
    tx_crs = 1; tick(50); tx_crs = 0; tick(40); tx_crs = 1;
    watch(200, r, h);
    check("R9 cancelled burst", h, 0);
    tx_crs = 0; tick(250);

    // loopback
    loop_test = 1; tick(2);
    tx_crs = 1; tick(50); tx_crs = 0;
    watch(250, r, h);
    check("R8 no heartbeat in loop", r, 0);
    tx_crs = 1; tick(JAB + 50);
    check("R8 no jabber in loop", tx_en, 1);
    tx_crs = 0; loop_test = 0; sqe_en = 0; tick(GAP + 10);

    // reset clears jabber
    tx_crs = 1; tick(JAB + 10);
    check("R10 jabbed before reset", tx_en, 0);
    tx_crs = 0; rst_n = 0; tick(3); rst_n = 1; tick(1);
    check("R10 tx_en after reset", tx_en, 1);
    watch(20, r, h);
    check("R10 ci quiet after reset", r, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    tick(100_000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule